// File: doc/BRIEF.md
# SDRAM Bank-Aware Command Sequencer

This block turns single read and write requests from a local client into the command stream of a DDR or DDR2 SDRAM device. It keeps a table of the row held open in every bank. A request to an open row goes straight to a column command. A request to a closed bank first gets an activate. A request to a bank that holds a different row gets a single-bank precharge, then an activate, and only then the column command. Only NOP cycles are placed between commands until the relevant spacing (row-to-column, precharge, refresh, mode-load or burst length) has elapsed.

Out of reset the sequencer closes every bank and programs the device mode register with CAS latency, burst length and burst type. Only then does it accept traffic. A free-running interval timer requests auto-refresh. The refresh is served at the next point where no request is in flight: open banks are closed with a precharge-all, then the refresh command is issued. A read burst can be cut short with a burst-terminate command from a local stop input. The physical pads, data path and read capture belong to other blocks.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset release the first command is a precharge-all (PCH with address bit 10 high, bank 0). A mode-register load follows T_RP cycles later. `req_ready` stays low from reset until T_MRD cycles after the mode-register load, and only NOPs appear in between.
- R2: Commands are driven on {`mem_cs_n`,`mem_ras_n`,`mem_cas_n`,`mem_we_n`} as: NOP=0111, ACT=0011, RD=0101, WR=0100, BT=0110, PCH=0010, ARF=0001, LMR=0000.
- R3: The mode-register load drives bank 0 and an address word with burst length code in bits 2:0 (2→1, 4→2, 8→3), burst type in bit 3 (1 = interleaved) and CAS latency in bits 6:4. All other bits are zero.
- R4: A request to a closed bank issues ACT with that bank on `mem_ba` and the row on `mem_a`. The column command follows exactly T_RCD cycles later.
- R5: A request to the row already open in its bank produces its RD or WR in the cycle after acceptance, with no ACT or PCH.
- R6: A request to a bank holding another row issues PCH with address bit 10 low for that bank. ACT follows T_RP cycles later, and then the column command T_RCD cycles after that.
- R7: A column command is WR when `req_write` was 1 and RD otherwise. The column sits in the low bits of `mem_a`, bit 10 is low and the bank is on `mem_ba`. The request address is packed {bank, row, column} from the top bit down.
- R8: After RD or WR, the next command other than BT comes no earlier than BURST_LEN/2 cycles later.
- R9: `burst_stop` high during a read burst window makes BT appear in the next cycle and ends the window. `burst_stop` outside a read burst, including during a write burst, has no effect on the command stream.
- R10: Refresh falls due every T_REFI cycles after reset. Open banks are closed with one precharge-all, ARF follows T_RP later with no bank open, and the next command comes T_RFC cycles after ARF. Any later access then needs a fresh ACT.
- R11: A request already accepted is carried through to its column command before a due refresh is served. `req_ready` is low while a refresh is due.
- R12: `req_ready` is high only when the sequencer is idle, running and has no refresh due. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R13: In every cycle without another command, NOP is driven with `mem_ba` and `mem_a` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+ROW_W+COL_W | Request address {bank, row, column} |
| burst_stop | input | 1 | Ask for burst termination of the running read burst |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BANK_W | Bank address |
| mem_a | output | ROW_W | Row, column or mode word |

## Verification
The refresh timer can expire in the same cycle that a local request is presented, or while a row-miss sequence is only part done. The bench provokes this with stretches of back-to-back requests to a few rows, so that a request is almost always waiting when the interval lapses. A reference model written with plain integers in the bench predicts every command, bank, address and ready value, and the outputs are compared with it on every clock. For a correct result, the request in flight finishes with its column command first, then the precharge-all and ARF follow, and the waiting request is accepted only after the refresh spacing.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_ARF = 4'b0001,
    CMD_PCH = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BT  = 4'b0110,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    PH_INIT_PCH = 2'd0,
    PH_INIT_LMR = 2'd1,
    PH_RUN      = 2'd2
  } seq_phase_e;

endpackage

// File: rtl/seq_open_rows.sv
module seq_open_rows #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] sel_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic              set_en,
  input  logic              clr_one_en,
  input  logic              clr_all_en,
  output logic              sel_open,
  output logic [ROW_W-1:0]  sel_row,
  output logic [BANKS-1:0]  open_vec
);

  logic [ROW_W-1:0] rows [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             vld_q, vld_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic             hit_bank;
    logic             upd_en;

    assign hit_bank = (sel_bank == BANK_W'(b));
    assign upd_en   = clr_all_en || (hit_bank && (set_en || clr_one_en));

    always_comb begin
      vld_d = vld_q;
      row_d = row_q;
      if (clr_all_en || (hit_bank && clr_one_en)) begin
        vld_d = 1'b0;
      end else if (hit_bank && set_en) begin
        vld_d = 1'b1;
        row_d = set_row;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        row_q <= '0;
      end else if (upd_en) begin
        vld_q <= vld_d;
        row_q <= row_d;
      end
    end

    assign open_vec[b] = vld_q;
    assign rows[b]     = row_q;
  end

  assign sel_open = open_vec[sel_bank];
  assign sel_row  = rows[sel_bank];

endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
  parameter int T_REFI = 300,
  parameter int CNT_W  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served,
  output logic due
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             due_q, due_d;
  logic             lapse;

  assign lapse = (cnt_q == CNT_W'(T_REFI - 1));

  always_comb begin
    cnt_d = lapse ? '0 : cnt_q + 1'b1;
    if (lapse)       due_d = 1'b1;
    else if (served) due_d = 1'b0;
    else             due_d = due_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      due_q <= due_d;
    end
  end

  assign due = due_q;

  // R10
  due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (due_q && !served) |=> due_q);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANKS            = 4,
  parameter int ROW_W            = 13,
  parameter int COL_W            = 10,
  parameter int T_RCD            = 3,
  parameter int T_RP             = 3,
  parameter int T_RFC            = 9,
  parameter int T_MRD            = 2,
  parameter int T_REFI           = 300,
  parameter int CAS_LAT          = 3,
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int BANK_W           = $clog2(BANKS),
  parameter int REQ_W            = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [REQ_W-1:0]  req_addr,
  input  logic              burst_stop,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BANK_W-1:0] mem_ba,
  output logic [ROW_W-1:0]  mem_a
);

  localparam int ADDR_W = ROW_W;
  localparam int GAP    = BURST_LEN / 2;
  localparam int WAIT_W = $clog2(T_RCD + T_RP + T_RFC + T_MRD + BURST_LEN + 1);
  localparam int REF_W  = $clog2(T_REFI + 1);
  localparam int A10    = 10;
  localparam logic [2:0] BL_CODE = (BURST_LEN == 8) ? 3'd3 :
                                   (BURST_LEN == 4) ? 3'd2 : 3'd1;
  localparam logic [ADDR_W-1:0] MODE_WORD =
    {{(ADDR_W-7){1'b0}}, 3'(CAS_LAT), 1'(BURST_INTERLEAVE), BL_CODE};

  seq_phase_e         phase_q, phase_d;
  logic [WAIT_W-1:0]  wait_q, wait_d;
  logic               burst_q, burst_d;
  logic               hold_q, hold_d;
  logic               hold_wr_q;
  logic [REQ_W-1:0]   hold_addr_q;
  sdram_cmd_e         cmd_q, cmd_d;
  logic [BANK_W-1:0]  ba_q, ba_d;
  logic [ADDR_W-1:0]  a_q, a_d;

  logic               accept;
  logic               cur_wr;
  logic [REQ_W-1:0]   cur_addr;
  logic [BANK_W-1:0]  cur_bank;
  logic [ROW_W-1:0]   cur_row;
  logic [COL_W-1:0]   cur_col;
  logic               tbl_set, tbl_clr_one, tbl_clr_all;
  logic               sel_open;
  logic [ROW_W-1:0]   sel_row;
  logic [BANKS-1:0]   open_vec;
  logic               ref_due, ref_served;

  assign req_ready = (phase_q == PH_RUN) && (wait_q == '0) && !hold_q && !ref_due;
  assign accept    = req_valid && req_ready;
  assign cur_wr    = hold_q ? hold_wr_q   : req_write;
  assign cur_addr  = hold_q ? hold_addr_q : req_addr;
  assign cur_bank  = cur_addr[REQ_W-1 -: BANK_W];
  assign cur_row   = cur_addr[COL_W +: ROW_W];
  assign cur_col   = cur_addr[COL_W-1:0];

  seq_open_rows #(.BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_bank   (cur_bank),
    .set_row    (cur_row),
    .set_en     (tbl_set),
    .clr_one_en (tbl_clr_one),
    .clr_all_en (tbl_clr_all),
    .sel_open   (sel_open),
    .sel_row    (sel_row),
    .open_vec   (open_vec)
  );

  seq_refresh_timer #(.T_REFI(T_REFI), .CNT_W(REF_W)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .served (ref_served),
    .due    (ref_due)
  );

  always_comb begin
    cmd_d       = CMD_NOP;
    ba_d        = '0;
    a_d         = '0;
    phase_d     = phase_q;
    wait_d      = (wait_q != '0) ? wait_q - 1'b1 : '0;
    burst_d     = burst_q && (wait_q > WAIT_W'(1));
    hold_d      = hold_q;
    tbl_set     = 1'b0;
    tbl_clr_one = 1'b0;
    tbl_clr_all = 1'b0;
    ref_served  = 1'b0;
    if (wait_q != '0) begin
      if (burst_q && burst_stop) begin
        cmd_d   = CMD_BT;
        wait_d  = '0;
        burst_d = 1'b0;
      end
    end else begin
      case (phase_q)
        PH_INIT_PCH: begin
          cmd_d       = CMD_PCH;
          a_d[A10]    = 1'b1;
          wait_d      = WAIT_W'(T_RP - 1);
          tbl_clr_all = 1'b1;
          phase_d     = PH_INIT_LMR;
        end
        PH_INIT_LMR: begin
          cmd_d   = CMD_LMR;
          a_d     = MODE_WORD;
          wait_d  = WAIT_W'(T_MRD - 1);
          phase_d = PH_RUN;
        end
        default: begin
          if (hold_q || accept) begin
            ba_d = cur_bank;
            if (sel_open && (sel_row == cur_row)) begin
              cmd_d   = cur_wr ? CMD_WR : CMD_RD;
              a_d     = ADDR_W'(cur_col);
              wait_d  = WAIT_W'(GAP - 1);
              burst_d = !cur_wr && (GAP > 1);
              hold_d  = 1'b0;
            end else if (sel_open) begin
              cmd_d       = CMD_PCH;
              wait_d      = WAIT_W'(T_RP - 1);
              tbl_clr_one = 1'b1;
              hold_d      = 1'b1;
            end else begin
              cmd_d   = CMD_ACT;
              a_d     = cur_row;
              wait_d  = WAIT_W'(T_RCD - 1);
              tbl_set = 1'b1;
              hold_d  = 1'b1;
            end
          end else if (ref_due) begin
            if (|open_vec) begin
              cmd_d       = CMD_PCH;
              a_d[A10]    = 1'b1;
              wait_d      = WAIT_W'(T_RP - 1);
              tbl_clr_all = 1'b1;
            end else begin
              cmd_d      = CMD_ARF;
              wait_d     = WAIT_W'(T_RFC - 1);
              ref_served = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INIT_PCH;
      wait_q  <= '0;
      burst_q <= 1'b0;
      hold_q  <= 1'b0;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      a_q     <= '0;
    end else begin
      phase_q <= phase_d;
      wait_q  <= wait_d;
      burst_q <= burst_d;
      hold_q  <= hold_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      a_q     <= a_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      hold_wr_q   <= req_write;
      hold_addr_q <= req_addr;
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign mem_ba = ba_q;
  assign mem_a  = a_q;

  // R5
  col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> open_vec[ba_q]);

  // R10
  arf_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ARF) |-> (open_vec == '0));

  // R11
  rdy_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ref_due);

  // R9
  bt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_BT) |-> $past(burst_stop));

  if (T_RCD > 1) begin : g_act_gap
    // R4
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));
  end

endmodule

// File: tb/sdram_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb;

  localparam int T_RCD = 3, T_RP = 3, T_RFC = 9, T_MRD = 2, T_REFI = 300;
  localparam int BL = 4, GAP = BL / 2;
  localparam logic [12:0] MODE = 13'h032; // R3: CL3 in 6:4, seq, BL4 code 2
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         BT = 4'b0110, PCH = 4'b0010, ARF = 4'b0001, LMR = 4'b0000;
  localparam int NCYC = 3600;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write, burst_stop;
  logic [24:0] req_addr;
  logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [1:0] mem_ba;
  logic [12:0] mem_a;

  sdram_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .burst_stop(burst_stop),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_a(mem_a)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_vec = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_phase, m_wait, m_refcnt;
  bit m_burst, m_hold, m_hwr, m_due;
  int m_hb, m_hr, m_hc;
  int orow [4];
  logic [3:0] e_cmd;
  logic [1:0] e_ba;
  logic [12:0] e_a;
  string e_tag;
  int n_coll = 0, o_arf = 0, o_bt = 0, o_miss = 0, o_col = 0, o_act = 0;

  task automatic chk(input string tag, input int act_v, input int exp_v, input string what);
    n_vec++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  function automatic bit m_ready();
    return (m_phase == 2) && (m_wait == 0) && !m_hold && !m_due;
  endfunction

  task automatic m_reset();
    m_phase = 0; m_wait = 0; m_refcnt = 0;
    m_burst = 0; m_hold = 0; m_due = 0; m_hwr = 0;
    m_hb = 0; m_hr = 0; m_hc = 0;
    foreach (orow[i]) orow[i] = -1;
  endtask

  // one clock edge of the behavioural model
  task automatic m_step(input bit v, input bit w, input int b, input int r, input int c, input bit stop);
    bit acc, cw, nb, nh, nd, arf;
    int cb, cr, cc, nw;
    acc = v && m_ready();
    if (v && m_due && m_phase == 2) n_coll++;
    e_cmd = NOP; e_ba = '0; e_a = '0; e_tag = "R8 R13";
    nw = (m_wait > 0) ? m_wait - 1 : 0;
    nb = m_burst && (m_wait > 1);
    nh = m_hold; arf = 0;
    if (m_hold) begin cw = m_hwr; cb = m_hb; cr = m_hr; cc = m_hc; end
    else begin cw = w; cb = b; cr = r; cc = c; end
    if (m_wait > 0) begin
      if (m_burst && stop) begin e_cmd = BT; nw = 0; nb = 0; e_tag = "R9"; end
    end else if (m_phase == 0) begin
      e_cmd = PCH; e_a = 13'h400; nw = T_RP - 1; m_phase = 1; e_tag = "R1";
    end else if (m_phase == 1) begin
      e_cmd = LMR; e_a = MODE; nw = T_MRD - 1; m_phase = 2; e_tag = "R2 R3";
    end else if (m_hold || acc) begin
      e_ba = 2'(cb);
      if (orow[cb] == cr) begin
        e_cmd = cw ? WR : RD; e_a = 13'(cc); nw = GAP - 1; nb = !cw && (GAP > 1);
        nh = 0; e_tag = "R5 R7";
      end else if (orow[cb] >= 0) begin
        e_cmd = PCH; orow[cb] = -1; nw = T_RP - 1; nh = 1; e_tag = "R6";
      end else begin
        e_cmd = ACT; e_a = 13'(cr); orow[cb] = cr; nw = T_RCD - 1; nh = 1; e_tag = "R4";
      end
      if (acc) begin m_hwr = w; m_hb = b; m_hr = r; m_hc = c; end
    end else if (m_due) begin
      if (orow[0] >= 0 || orow[1] >= 0 || orow[2] >= 0 || orow[3] >= 0) begin
        e_cmd = PCH; e_a = 13'h400; foreach (orow[i]) orow[i] = -1;
        nw = T_RP - 1; e_tag = "R10 R11";
      end else begin
        e_cmd = ARF; nw = T_RFC - 1; arf = 1; e_tag = "R10";
      end
    end
    if (m_refcnt == T_REFI - 1) begin m_refcnt = 0; nd = 1; end
    else begin m_refcnt++; nd = arf ? 1'b0 : m_due; end
    m_wait = nw; m_burst = nb; m_hold = nh; m_due = nd;
  endtask

  initial begin
    bit p_v, p_w, rdy;
    int p_b, p_r, p_c, rate;
    void'($urandom(32'd11));
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = '0; burst_stop = 0;
    p_v = 0; p_w = 0; p_b = 0; p_r = 0; p_c = 0;
    repeat (3) @(negedge clk);
    // R1 R13: reset state
    chk("R1", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, NOP, "reset cmd");
    chk("R13", {mem_ba, mem_a}, 0, "reset bank/addr");
    chk("R1", req_ready, 0, "reset ready");
    m_reset();
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      // traffic phases: mixed, idle (refresh with banks closed), saturated (R11)
      rate = (cyc < 1500) ? 6 : (cyc < 2200) ? 0 : 10;
      if (!p_v && ($urandom % 10) < rate) begin
        p_v = 1; p_w = $urandom % 2; p_b = $urandom % 4; p_r = $urandom % 3;
        p_c = $urandom % 1024;
      end
      req_valid  = p_v;
      req_write  = p_w;
      req_addr   = {2'(p_b), 13'(p_r), 10'(p_c)};
      burst_stop = (($urandom % 10) < 3);
      #1;
      rdy = m_ready();
      chk("R12", req_ready, rdy, "req_ready");
      m_step(p_v, p_w, p_b, p_r, p_c, burst_stop);
      if (p_v && rdy) p_v = 0;
      @(negedge clk);
      chk(e_tag, {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, e_cmd, "command");
      chk(e_tag, mem_ba, e_ba, "bank");
      chk(e_tag, mem_a, e_a, "address");
      case ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n})
        ARF: o_arf++;
        BT:  o_bt++;
        ACT: o_act++;
        RD, WR: o_col++;
        PCH: if (!mem_a[10]) o_miss++;
        default: ;
      endcase
    end
    // coverage of the corner cases the requirements call out
    chk("R10", (o_arf >= NCYC / T_REFI - 1) ? 1 : 0, 1, "refresh count enough");
    chk("R9", (o_bt > 0) ? 1 : 0, 1, "burst terminate seen");
    chk("R6", (o_miss > 0) ? 1 : 0, 1, "row miss precharge seen");
    chk("R5", (o_col > o_act) ? 1 : 0, 1, "row hits without ACT seen");
    chk("R11", (n_coll > 0) ? 1 : 0, 1, "refresh met waiting request");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule